// File: doc/BRIEF.md
# Multiplexer-Array Dual-Basis Field Multiplier

This block multiplies two elements of the binary extension field GF(2^M). The field is defined by the trinomial 1 + x^N + x^M. The first operand arrives as coordinates in the dual basis, and the second as coordinates in the ordinary polynomial basis. The product leaves in the dual basis. This mixed representation lets a datapath that keeps a running value in the dual basis multiply it by constants or data held in polynomial form, without converting either operand.

The datapath has four parts:
- **Coordinate extension.** A linear extension of the dual-basis operand produces the M-1 extra coordinates that the product's Hankel structure needs.
- **Pair XOR.** Polynomial-basis bits are paired two at a time, and the XOR of each pair is formed once.
- **Multiplexer array.** A grid of 4-to-1 multiplexers follows. Each cell takes two dual-basis coordinates as its select. It returns zero, one bit of a pair, the other bit, or the pair's XOR. Each cell therefore absorbs two polynomial bits at once.
- **XOR trees.** A balanced XOR tree per output coordinate folds the ceil(M/2) cell outputs.

The result is captured in an output register with a synchronous, active-high reset.

Top module: `gf_dual_basis_mult`

## Requirements
- R1: The product output is registered. It changes only at a rising clock edge, and it shows the product of the operands sampled at the previous rising edge.
- R2: While `rst` is high at a rising edge, the output register is loaded with all zeros.
- R3: Extended coordinates follow a_{M+d} = a_d XOR a_{N+d} for 0 <= d <= M-2. With `b_poly` holding only bit M-1, output bit j equals a_{M-1+j}, which exposes every extended coordinate.
- R4: For general operands, output bit j equals the XOR over i of (b_i AND a_{i+j}), for 0 <= j <= M-1. Port bit k carries coordinate k on all three data ports.
- R5: If either operand is all zeros, the registered product is all zeros.
- R6: With `b_poly` equal to 1 (only bit 0 set), the registered product equals `a_dual`.
- R7: With `b_poly` equal to 2 (only bit 1 set), output bits 0..M-2 equal `a_dual` bits 1..M-1, and output bit M-1 equals a_0 XOR a_N.
- R8: For odd M, the missing last column and row are treated as zero. The result still obeys the R4 formula.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the product register captures on the rising edge |
| rst | input | 1 | Synchronous active-high reset of the product register |
| a_dual | input | M | First operand, dual-basis coordinates a_0..a_{M-1} |
| b_poly | input | M | Second operand, polynomial-basis coordinates b_0..b_{M-1} |
| c_dual | output | M | Registered product, dual-basis coordinates c_0..c_{M-1} |

## Verification
Each product is due exactly one rising edge after its operands are presented. The bench changes operands on a falling edge and compares `c_dual` at the following falling edge, half a period clear of the capture edge. To test the latency itself, the bench also samples the output just after new operands are driven and before the next rising edge. There the previous product must still be present. The reset result is read at the falling edge after a rising edge with `rst` high, while the operands are non-zero.

// File: rtl/dbm_pkg.sv
package dbm_pkg;

  // Number of two-bit groups needed to cover m polynomial coordinates.
  function automatic int half_up(input int m);
    return (m + 1) / 2;
  endfunction

  // Width of the extended dual-basis coordinate vector a_0..a_{2m-2}.
  function automatic int ext_width(input int m);
    return 2 * m - 1;
  endfunction

endpackage

// File: rtl/dbm_trace_ext.sv
module dbm_trace_ext #(
  parameter int M  = 4,
  parameter int N  = 1,
  parameter int EW = 2 * M - 1
) (
  input  logic [M-1:0]  a_in,
  output logic [EW-1:0] ext
);

  // Each new coordinate depends only on lower-indexed ones, so a single
  // ordered pass builds the whole vector without feedback.
  always_comb begin
    ext = '0;
    ext[M-1:0] = a_in;
    for (int d = 0; d <= M - 2; d++) begin
      ext[M+d] = ext[d] ^ ext[N+d];
    end
  end

endmodule

// File: rtl/dbm_pair_xor.sv
module dbm_pair_xor #(
  parameter int M = 4,
  parameter int H = (M + 1) / 2
) (
  input  logic [M-1:0]   b_in,
  output logic [2*H-1:0] b_pad,
  output logic [H-1:0]   b_pair
);

  // Zero-extend to an even width; for odd M the top bit is the empty row.
  always_comb begin
    b_pad = '0;
    b_pad[M-1:0] = b_in;
  end

  for (genvar g = 0; g < H; g++) begin : g_pair
    assign b_pair[g] = b_pad[2*g] ^ b_pad[2*g+1];
  end

endmodule

// File: rtl/dbm_mux4.sv
module dbm_mux4 (
  input  logic sel_u,
  input  logic sel_v,
  input  logic bu,
  input  logic bv,
  input  logic buv,
  output logic f
);

  // f = sel_u*bu XOR sel_v*bv, chosen from precomputed candidates.
  always_comb begin
    case ({sel_u, sel_v})
      2'b00:   f = 1'b0;
      2'b01:   f = bv;
      2'b10:   f = bu;
      default: f = buv;
    endcase
  end

endmodule

// File: rtl/dbm_xor_tree.sv
module dbm_xor_tree #(
  parameter int W = 2
) (
  input  logic [W-1:0] leaves,
  output logic         root
);

  localparam int L = (W > 1) ? $clog2(W) : 0;
  localparam int P = 1 << L;

  // Heap-ordered node array: node k combines nodes 2k and 2k+1, giving a
  // tree of depth L instead of a W-long chain.
  logic [2*P-1:1] node;

  always_comb begin
    node = '0;
    for (int k = 0; k < W; k++) begin
      node[P+k] = leaves[k];
    end
    for (int k = P - 1; k >= 1; k--) begin
      node[k] = node[2*k] ^ node[2*k+1];
    end
  end

  assign root = node[1];

endmodule

// File: rtl/gf_dual_basis_mult.sv
module gf_dual_basis_mult #(
  parameter int M = 4,
  parameter int N = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [M-1:0] a_dual,
  input  logic [M-1:0] b_poly,
  output logic [M-1:0] c_dual
);

  localparam int H  = dbm_pkg::half_up(M);
  localparam int EW = dbm_pkg::ext_width(M);
  localparam bit ODD = (M % 2) == 1;

  if (M < 2 || N < 1 || N >= M) begin : g_param_bad
    $error("gf_dual_basis_mult: need M >= 2 and 0 < N < M");
  end

  logic [EW-1:0]  ext;
  logic [2*H-1:0] b_pad;
  logic [H-1:0]   b_pair;
  logic [M-1:0]   c_next;

  dbm_trace_ext #(.M(M), .N(N), .EW(EW)) u_ext (
    .a_in (a_dual),
    .ext  (ext)
  );

  dbm_pair_xor #(.M(M), .H(H)) u_pair (
    .b_in   (b_poly),
    .b_pad  (b_pad),
    .b_pair (b_pair)
  );

  // Row i produces output coordinate i; column j consumes b_{2j}, b_{2j+1}.
  for (genvar i = 0; i < M; i++) begin : g_row
    logic [H-1:0] cell_out;

    for (genvar j = 0; j < H; j++) begin : g_col
      logic sel_v;
      if (ODD && j == H - 1) begin : g_pad_col
        assign sel_v = 1'b0;
      end else begin : g_full_col
        assign sel_v = ext[2*j+i+1];
      end

      dbm_mux4 u_cell (
        .sel_u (ext[2*j+i]),
        .sel_v (sel_v),
        .bu    (b_pad[2*j]),
        .bv    (b_pad[2*j+1]),
        .buv   (b_pair[j]),
        .f     (cell_out[j])
      );
    end

    dbm_xor_tree #(.W(H)) u_sum (
      .leaves (cell_out),
      .root   (c_next[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) c_dual <= '0;
    else     c_dual <= c_next;
  end

  // Output register is cleared when reset is released.
  assert_reset_clear_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (c_dual == '0));

  // A zero operand yields a zero product one edge later.
  assert_zero_operand_R5: assert property (@(posedge clk) disable iff (rst)
    ((a_dual == '0) || (b_poly == '0)) |=> (c_dual == '0));

  // Multiplying by the field unit returns the dual-basis operand.
  assert_unit_operand_R6: assert property (@(posedge clk) disable iff (rst)
    (b_poly == M'(1)) |=> (c_dual == $past(a_dual)));

  // Multiplying by alpha shifts coordinates and folds in the trinomial.
  assert_alpha_operand_R7: assert property (@(posedge clk) disable iff (rst)
    (b_poly == M'(2)) |=>
      (c_dual == {$past(a_dual[0] ^ a_dual[N]), $past(a_dual[M-1:1])}));

endmodule

// File: tb/test_gf_dual_basis_mult.sv
module test_gf_dual_basis_mult;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [15:0] a4, b4, a7, b7, a6, b6, a5, b5;
  logic [3:0] c4;
  logic [6:0] c7;
  logic [5:0] c6;
  logic [4:0] c5;

  gf_dual_basis_mult #(.M(4), .N(1)) i_gf_dual_basis_mult (
    .clk(clk), .rst(rst), .a_dual(a4[3:0]), .b_poly(b4[3:0]), .c_dual(c4));
  gf_dual_basis_mult #(.M(7), .N(1)) i_gf_dual_basis_mult_m7 (
    .clk(clk), .rst(rst), .a_dual(a7[6:0]), .b_poly(b7[6:0]), .c_dual(c7));
  gf_dual_basis_mult #(.M(6), .N(1)) i_gf_dual_basis_mult_m6 (
    .clk(clk), .rst(rst), .a_dual(a6[5:0]), .b_poly(b6[5:0]), .c_dual(c6));
  gf_dual_basis_mult #(.M(5), .N(2)) i_gf_dual_basis_mult_m5 (
    .clk(clk), .rst(rst), .a_dual(a5[4:0]), .b_poly(b5[4:0]), .c_dual(c5));

  // Reference: extend by the trinomial recurrence, then Hankel AND/XOR.
  function automatic logic [15:0] ref_mul(input int m, input int n,
                                          input logic [15:0] a,
                                          input logic [15:0] b);
    logic [31:0] e;
    logic [15:0] r;
    e = '0;
    r = '0;
    for (int k = 0; k < m; k++) e[k] = a[k];
    for (int d = 0; d <= m - 2; d++) e[m+d] = e[d] ^ e[n+d];
    for (int j = 0; j < m; j++) begin
      logic acc;
      acc = 1'b0;
      for (int i = 0; i < m; i++) acc = acc ^ (b[i] & e[i+j]);
      r[j] = acc;
    end
    return r;
  endfunction

  function automatic logic [15:0] mask(input int m, input logic [15:0] v);
    return v & ((16'h1 << m) - 16'h1);
  endfunction

  task automatic report(input string tag, input int m,
                        input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s M=%0d actual=%h expected=%h", tag, m, act, exp);
    end
  endtask

  task automatic chk(input int m, input int n, input logic [15:0] a,
                     input logic [15:0] b, input logic [15:0] act);
    logic [15:0] am, bm;
    string tag;
    am = mask(m, a);
    bm = mask(m, b);
    if (am == 0 || bm == 0)                 tag = "R5";
    else if (bm == 16'h1)                   tag = "R6";
    else if (bm == 16'h2)                   tag = "R7";
    else if (bm == (16'h1 << (m - 1)))      tag = "R3";
    else if (m % 2 == 1)                    tag = "R8";
    else                                    tag = "R4";
    report(tag, m, act, ref_mul(m, n, am, bm));
  endtask

  task automatic check_all();
    chk(4, 1, a4, b4, {12'b0, c4});
    chk(7, 1, a7, b7, {9'b0, c7});
    chk(6, 1, a6, b6, {10'b0, c6});
    chk(5, 2, a5, b5, {11'b0, c5});
  endtask

  task automatic randomize_all();
    a4 = 16'($urandom); b4 = 16'($urandom);
    a7 = 16'($urandom); b7 = 16'($urandom);
    a6 = 16'($urandom); b6 = 16'($urandom);
    a5 = 16'($urandom); b5 = 16'($urandom);
  endtask

  // Called on a falling edge with inputs already set; checks one edge later.
  task automatic step_and_check();
    @(negedge clk);
    check_all();
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    a4 = '1; b4 = '1; a7 = '1; b7 = '1; a6 = '1; b6 = '1; a5 = '1; b5 = '1;
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    // R2: reset clears the product even with non-zero operands.
    report("R2", 4, {12'b0, c4}, 16'h0);
    report("R2", 7, {9'b0, c7}, 16'h0);
    report("R2", 6, {10'b0, c6}, 16'h0);
    report("R2", 5, {11'b0, c5}, 16'h0);
    rst = 1'b0;

    // R4: every operand pair for M=4, others random.
    for (int v = 0; v < 256; v++) begin
      randomize_all();
      a4 = {12'b0, 4'(v)};
      b4 = {12'b0, 4'(v >> 4)};
      step_and_check();
    end

    // R3, R5, R6, R7: directed polynomial operands on every instance.
    for (int k = 0; k < 4; k++) begin
      for (int r = 0; r < 8; r++) begin
        randomize_all();
        case (k)
          0: begin b4 = 0; b7 = 0; b6 = 0; b5 = 0; end
          1: begin b4 = 1; b7 = 1; b6 = 1; b5 = 1; end
          2: begin b4 = 2; b7 = 2; b6 = 2; b5 = 2; end
          default: begin b4 = 16'h8; b7 = 16'h40; b6 = 16'h20; b5 = 16'h10; end
        endcase
        step_and_check();
      end
    end
    // R5: zero dual-basis operand.
    randomize_all();
    a4 = 0; a7 = 0; a6 = 0; a5 = 0;
    step_and_check();

    // R4, R8: random operands, including odd M.
    for (int r = 0; r < 300; r++) begin
      randomize_all();
      step_and_check();
    end

    // R1: the output holds the old product until the next rising edge.
    for (int r = 0; r < 8; r++) begin
      logic [15:0] pa, pb;
      randomize_all();
      step_and_check();
      pa = a4; pb = b4;
      a4 = 16'($urandom); b4 = 16'($urandom);
      #1;
      report("R1", 4, {12'b0, c4}, ref_mul(4, 1, mask(4, pa), mask(4, pb)));
      step_and_check();
    end

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule